// File: doc/BRIEF.md
# Interrupt Backlog Counter Window Decoder

This block sits behind two memory-mapped windows of an interrupt controller. Every access that lands in a window acts on a small backlog counter. Loads and stores both have this side effect. The block splits the address into a page number and a 12-bit operation code. It checks the access width, which differs for loads and stores, and picks one of three counter banks. It then increments or decrements the chosen counter with saturation. A load returns the counter value as it was before the update.

The first window (`req_win` = 0) maps each page straight onto a crowd counter. The second window (`req_win` = 1) interleaves two counter kinds page by page. Odd pages reach group counters and even pages reach processor counters, and both use the page number halved as the index. Software uses 2-byte loads to bump a counter by one and read the old value. It uses 1-byte stores to move a group or crowd counter by an arbitrary amount.

Top module: `bklg_mmio`

## Requirements
- R1: The operation code is address bits [11:0]. The page number is the address bits from `PAGE_SHIFT` upward. Bits between 12 and `PAGE_SHIFT` have no effect.
- R2: In window 0 the page number is the index into the crowd bank.
- R3: In window 1 an odd page selects the group bank and an even page selects the processor bank. Both use index = page >> 1.
- R4: A load with `req_size` other than 2 leaves all counters unchanged and returns 16'hFFFF.
- R5: A store with `req_size` other than 1 leaves all counters unchanged.
- R6: A valid load changes its counter by 1. It returns the counter value from before the update, zero-extended to 16 bits.
- R7: A valid store to a crowd or group counter changes it by the byte on `req_wdata`. A store to a processor counter ignores `req_wdata` and changes the counter by 1.
- R8: Operation bit 0 sets the direction: 0 increments and 1 decrements. If any of operation bits [11:1] is set, a request that passes the R4/R5/R10 checks leaves the counters unchanged, and a load returns 0.
- R9: Counters are 8 bits wide. An increment saturates at 255 and a decrement saturates at 0.
- R10: A bank index of `NUM_CNT` or more gets the same error response as a bad size. A load returns 16'hFFFF and a store is dropped.
- R11: Each load raises `rsp_valid` for one cycle on the clock edge after the request, with `rsp_data`. A store raises no response. The counter update is visible to a request in the very next cycle.
- R12: After reset all counters are 0 and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_win | input | 1 | 0: crowd window, 1: interleaved processor/group window |
| req_write | input | 1 | 1: store, 0: load |
| req_addr | input | ADDR_W | Byte offset inside the selected window |
| req_size | input | 4 | Access width in bytes (1 to 8) |
| req_wdata | input | CNT_W | Store byte (the amount) |
| rsp_valid | output | 1 | Load response strobe |
| rsp_data | output | RSP_W | Load data |

## Verification
The hardest behaviour to reach is the pairing of the interleaved steering with saturation. An odd page and the even page next to it share an index but must touch separate banks. Each bank must clip at its own limits. The bench first loads distinct amounts into every page of both windows, so any cross-talk between banks shows up in later loads. It then drives one crowd counter into both rails with 255-sized stores. The bench widens `PAGE_SHIFT` to 13 and sets the unused bit 12 on many requests, so a wrong address split shows up as a wrong counter.

// File: rtl/bklg_pkg.sv
package bklg_pkg;
  typedef enum logic [1:0] {
    K_CROWD = 2'd0,
    K_GROUP = 2'd1,
    K_PROC  = 2'd2
  } bklg_kind_e;

  localparam int OP_W     = 12;
  localparam int NUM_KIND = 3;
  localparam int LD_BYTES = 2;
  localparam int ST_BYTES = 1;
endpackage

// File: rtl/bklg_decode.sv
module bklg_decode
  import bklg_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_CNT    = 8,
  parameter int CNT_W      = 8,
  localparam int IDX_W     = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int PAGE_W    = ADDR_W - PAGE_SHIFT
) (
  input  logic              win,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  input  logic [CNT_W-1:0]  wdata,
  output bklg_kind_e        kind,
  output logic [IDX_W-1:0]  idx,
  output logic              fault,
  output logic              noop,
  output logic              dec,
  output logic [CNT_W-1:0]  amount
);
  logic [PAGE_W-1:0] page;
  logic [OP_W-1:0]   op;
  logic [PAGE_W-1:0] full_idx;
  logic              size_ok;
  logic              range_ok;

  always_comb begin
    page     = addr[ADDR_W-1:PAGE_SHIFT];
    op       = addr[OP_W-1:0];
    full_idx = win ? (page >> 1) : page;
    if (!win)        kind = K_CROWD;
    else if (page[0]) kind = K_GROUP;
    else             kind = K_PROC;
    size_ok  = write ? (size == 4'(ST_BYTES)) : (size == 4'(LD_BYTES));
    range_ok = 32'(full_idx) < NUM_CNT;
    fault    = !size_ok || !range_ok;
    noop     = op[OP_W-1:1] != '0;
    dec      = op[0];
    amount   = (!write || kind == K_PROC) ? CNT_W'(1) : wdata;
    idx      = full_idx[IDX_W-1:0];
  end
endmodule

// File: rtl/bklg_bank.sv
module bklg_bank #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 8,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic             dec,
  input  logic [CNT_W-1:0] amount,
  output logic [CNT_W-1:0] rd_val
);
  logic [CNT_W-1:0] mem [NUM_CNT];
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    rd_val = mem[idx];
    sum    = {1'b0, rd_val} + {1'b0, amount};
    if (dec) nxt = (amount > rd_val) ? '0 : rd_val - amount;
    else     nxt = sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_CNT; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= nxt;
    end
  end
endmodule

// File: rtl/bklg_mmio.sv
module bklg_mmio
  import bklg_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_CNT    = 8,
  parameter int CNT_W      = 8,
  parameter int RSP_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_win,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [CNT_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [RSP_W-1:0]  rsp_data
);
  localparam int IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  bklg_kind_e       kind;
  logic [IDX_W-1:0] idx;
  logic             fault;
  logic             noop;
  logic             dec;
  logic [CNT_W-1:0] amount;
  logic [CNT_W-1:0] rd_vals [NUM_KIND];
  logic [CNT_W-1:0] old_val;

  bklg_decode #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)
  ) u_dec (
    .win(req_win), .write(req_write), .addr(req_addr), .size(req_size),
    .wdata(req_wdata), .kind(kind), .idx(idx), .fault(fault), .noop(noop),
    .dec(dec), .amount(amount)
  );

  for (genvar k = 0; k < NUM_KIND; k++) begin : g_bank
    logic we_k;
    assign we_k = req_valid && !fault && !noop && (int'(kind) == k);
    bklg_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst(rst), .we(we_k), .idx(idx), .dec(dec),
      .amount(amount), .rd_val(rd_vals[k])
    );
  end

  always_comb begin
    case (kind)
      K_GROUP: old_val = rd_vals[1];
      K_PROC:  old_val = rd_vals[2];
      default: old_val = rd_vals[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        if (fault)     rsp_data <= '1;
        else if (noop) rsp_data <= '0;
        else           rsp_data <= RSP_W'(old_val);
      end
    end
  end
endmodule

// File: rtl/bklg_mmio_chk.sv
module bklg_mmio_chk #(
  parameter int ADDR_W     = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int NUM_CNT    = 8,
  parameter int RSP_W      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_win,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_size,
  input logic              rsp_valid,
  input logic [RSP_W-1:0]  rsp_data
);
  logic load_req;
  logic crowd_in_range;
  logic reserved_op;
  assign load_req       = req_valid && !req_write;
  assign crowd_in_range = !req_win && (32'(req_addr[ADDR_W-1:PAGE_SHIFT]) < NUM_CNT);
  assign reserved_op    = (req_addr[11:0] != 12'h000) && (req_addr[11:0] != 12'h001);

  a_r11_load_resp: assert property (@(posedge clk) disable iff (rst)
    load_req |=> rsp_valid);
  a_r11_store_silent: assert property (@(posedge clk) disable iff (rst)
    !load_req |=> !rsp_valid);
  a_r4_bad_load_ones: assert property (@(posedge clk) disable iff (rst)
    (load_req && req_size != 4'd2) |=> (rsp_data == '1));
  a_r6_zero_extend: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_data != '1) |-> (rsp_data[RSP_W-1:8] == '0));
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (load_req && req_size == 4'd2 && crowd_in_range && reserved_op) |=> (rsp_data == '0));
  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |=> !rsp_valid);
endmodule

bind bklg_mmio bklg_mmio_chk #(
  .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_CNT(NUM_CNT), .RSP_W(RSP_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_win(req_win),
  .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data)
);

// File: tb/bklg_mmio_bench.sv
module bklg_mmio_bench;
  localparam int ADDR_W = 21;
  localparam int PSH    = 13;
  localparam int NCNT   = 8;

  logic              clk = 0;
  logic              rst = 1;
  logic              req_valid = 0;
  logic              req_win = 0;
  logic              req_write = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_size = '0;
  logic [7:0]        req_wdata = '0;
  logic              rsp_valid;
  logic [15:0]       rsp_data;

  int tests = 0;
  int fails = 0;
  int model [3][NCNT];

  always #4 clk = ~clk;

  bklg_mmio #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PSH), .NUM_CNT(NCNT), .CNT_W(8), .RSP_W(16)) u_bklg_mmio (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_win(req_win),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  function automatic logic [ADDR_W-1:0] mk(int page, int op, bit junk);
    return {page[7:0], junk, op[11:0]};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one access at a falling edge; check the response at the next one.
  task automatic access(bit win, bit wr, logic [ADDR_W-1:0] addr, int size,
                        int data, string req);
    int page = int'(addr[ADDR_W-1:PSH]);
    int op   = int'(addr[11:0]);
    int idx  = win ? page / 2 : page;
    int kind = !win ? 0 : ((page % 2) == 1 ? 1 : 2);
    bit bad  = (wr ? size != 1 : size != 2) || idx >= NCNT;
    int exp  = 0;
    int amt  = (!wr || kind == 2) ? 1 : data;
    if (bad) exp = 16'hFFFF;
    else if (op > 1) exp = 0;
    else begin
      exp = model[kind][idx];
      if (op == 1) model[kind][idx] = (amt > exp) ? 0 : exp - amt;
      else model[kind][idx] = (exp + amt > 255) ? 255 : exp + amt;
    end
    req_valid = 1; req_win = win; req_write = wr; req_addr = addr;
    req_size = 4'(size); req_wdata = 8'(data);
    @(negedge clk);
    req_valid = 0;
    if (wr) chk(rsp_valid == 0, {req, " R11 store no rsp"}, int'(rsp_valid), 0);
    else begin
      chk(rsp_valid == 1, {req, " R11 rsp_valid"}, int'(rsp_valid), 1);
      chk(rsp_data == 16'(exp), req, int'(rsp_data), exp);
    end
  endtask

  task automatic load_all(string req);
    for (int p = 0; p < NCNT; p++) access(0, 0, mk(p, 0, p[0]), 2, 0, req);
    for (int p = 0; p < 2 * NCNT; p++) access(1, 0, mk(p, 0, p[1]), 2, 0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) for (int i = 0; i < NCNT; i++) model[k][i] = 0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R12 rsp_valid in reset", int'(rsp_valid), 0);
    rst = 0;
    @(negedge clk);
    chk(rsp_valid == 0, "R12 rsp_valid after reset", int'(rsp_valid), 0);
    load_all("R12 reset counters");   // also bumps each by 1

    // R2 / R7: crowd window, distinct store amounts
    for (int p = 0; p < NCNT; p++) access(0, 1, mk(p, 0, 1), 1, 3 * p + 5, "R7 crowd store");
    // R3 / R7: interleaved window, odd=group uses byte, even=proc ignores it
    for (int p = 0; p < 2 * NCNT; p++) access(1, 1, mk(p, 0, 1), 1, 40 + p, "R3 interleaved store");
    load_all("R2 R3 R6 after stores");
    load_all("R6 old value then increment");
    load_all("R1 page split repeat");

    // R8: decrement and reserved op codes
    for (int p = 0; p < NCNT; p++) access(0, 0, mk(p, 1, 0), 2, 0, "R8 load decrement");
    for (int p = 0; p < 2 * NCNT; p++) access(1, 1, mk(p, 1, 0), 1, 2, "R8 store decrement");
    access(0, 0, mk(2, 12'h002, 0), 2, 0, "R8 reserved op load");
    access(1, 0, mk(3, 12'h800, 1), 2, 0, "R8 reserved op load");
    access(0, 1, mk(2, 12'h010, 0), 1, 9, "R8 reserved op store");
    access(1, 1, mk(4, 12'hFFE, 0), 1, 9, "R8 reserved op store");
    load_all("R8 after decrements and reserved ops");

    // R4 / R5: bad sizes
    for (int s = 1; s <= 8; s++) if (s != 2) access(0, 0, mk(1, 0, 0), s, 0, "R4 bad load size");
    for (int s = 2; s <= 8; s++) access(1, 1, mk(5, 0, 0), s, 77, "R5 bad store size");
    for (int s = 2; s <= 8; s++) access(0, 1, mk(1, 0, 0), s, 77, "R5 bad store size");
    load_all("R4 R5 counters untouched");

    // R10: pages beyond the banks
    access(0, 0, mk(NCNT, 0, 0), 2, 0, "R10 crowd range load");
    access(0, 0, mk(255, 0, 0), 2, 0, "R10 crowd range load");
    access(1, 0, mk(2 * NCNT, 0, 0), 2, 0, "R10 proc range load");
    access(1, 0, mk(2 * NCNT + 1, 0, 0), 2, 0, "R10 group range load");
    access(0, 1, mk(NCNT + 3, 0, 0), 1, 50, "R10 range store");
    access(1, 1, mk(255, 0, 0), 1, 50, "R10 range store");
    load_all("R10 counters untouched");

    // R9: saturation at both rails, back-to-back
    access(0, 1, mk(0, 0, 0), 1, 255, "R9 inc saturate");
    access(0, 1, mk(0, 0, 0), 1, 255, "R9 inc saturate");
    access(0, 0, mk(0, 0, 0), 2, 0, "R9 high rail load");
    access(0, 0, mk(0, 1, 0), 2, 0, "R9 high rail dec");
    access(0, 1, mk(0, 1, 0), 1, 255, "R9 dec saturate");
    access(0, 0, mk(0, 1, 0), 2, 0, "R9 low rail load");
    access(0, 0, mk(0, 0, 0), 2, 0, "R9 low rail check");
    access(1, 1, mk(3, 0, 0), 1, 255, "R9 group saturate");
    access(1, 1, mk(3, 0, 0), 1, 255, "R9 group saturate");
    access(1, 0, mk(3, 0, 0), 2, 0, "R9 group high rail");
    load_all("R9 R3 banks independent");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule